// File: doc/BRIEF.md
# Timed Challenge Phase Pacer

This block walks a team through four equal-length time slots: a reading period, then the first, second and third challenge. An external interval timer, which is not part of this block, sends a one-cycle slot-end strobe each time a slot runs out. The pacer moves to the next phase only on that strobe. After the third challenge it parks in a finished state and raises its finished flag. It leaves that state only when the start button is pressed again.

Pressing start at any moment restarts the run at the reading period. It also asks the interval timer to restart, so that the first slot is full length. The same restart request is issued when the run finishes, so the timer is ready for the next team.

While a challenge is open, the block watches the activity values of the three challenges. It raises a conflict indication when a team is working on more than one challenge at a time. As long as no slot-end strobe arrives, the phase is held.

The six states are named IDLE, READ, CH1, CH2, CH3 and DONE. The transitions are:
- START: from any state to READ.
- TICK_READ: from READ to CH1.
- TICK_CH1: from CH1 to CH2.
- TICK_CH2: from CH2 to CH3.
- FINISH: from CH3 to DONE.
- HOLD: no strobe, so the state stays where it is.

An illegal state code falls back to IDLE.

Top module: `phase_pacer`

## Requirements
- R1: While reset is held, and after it is released, the block is in IDLE. All phase bits are 0, and done_o, tmr_restart_o and conflict_o are 0.
- R2: A clock edge with start_i = 1 puts the block in READ (phase_o = 4'b0001) from any state. This holds even when slot_end_i = 1 on the same edge.
- R3: Each edge with slot_end_i = 1 and start_i = 0 advances READ to CH1 to CH2 to CH3. The phase bits are one-hot: bit 0 is reading, bit 1 is challenge 1, bit 2 is challenge 2 and bit 3 is challenge 3.
- R4: An edge with start_i = 0 and slot_end_i = 0 leaves phase_o and done_o unchanged.
- R5: An edge with slot_end_i = 1 in CH3 enters DONE. In DONE, done_o = 1 and phase_o = 0. The block stays in DONE, whatever slot_end_i does, until start_i is seen.
- R6: tmr_restart_o is 1 for the cycle after each edge where start_i = 1, and for the one cycle after entering DONE. Otherwise it is 0.
- R7: In CH1, conflict_o is 1 in the same cycle when c1_act_i ≠ 0 and either c2_act_i ≠ 0 or c3_act_i ≠ 0. Otherwise it is 0. The phase is held while no strobe arrives.
- R8: In CH2, conflict_o is 1 in the same cycle when c2_act_i ≠ 0, c1_act_i = 0 and c3_act_i ≠ 0. Otherwise it is 0.
- R9: conflict_o is 0 in IDLE, READ, CH3 and DONE, whatever the activity inputs are.
- R10: In IDLE, slot_end_i has no effect. phase_o and done_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start button, level sampled each edge |
| slot_end_i | input | 1 | One-cycle strobe from the interval timer at the end of a slot |
| c1_act_i | input | C1_W (2) | Challenge 1 activity value |
| c2_act_i | input | C2_W (4) | Challenge 2 activity value |
| c3_act_i | input | C3_W (4) | Challenge 3 activity value |
| phase_o | output | 4 | One-hot phase: bit 0 read, bit 1 ch1, bit 2 ch2, bit 3 ch3 |
| done_o | output | 1 | Run finished, held until start |
| tmr_restart_o | output | 1 | One-cycle request to restart the interval timer |
| conflict_o | output | 1 | Multiple-challenge activity detected in the current phase |

## Verification
A wrong state shows up on phase_o or done_o one cycle after the edge that stored it. All outputs decode the state register directly, so there is no extra latency to wait for. A missing or extra advance leaves the phase sequence off by one slot for the rest of the run, and the bench compares every phase step against the expected value. A fault in the restart pulse or the conflict decode appears in the same cycle as its cause or the next one, so those are sampled right after the driving edge or right after the input change.

// File: rtl/phase_pacer_pkg.sv
package phase_pacer_pkg;
    localparam int STATE_W = 3;
    localparam int PHASES  = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_CH1  = 3'd2,
        ST_CH2  = 3'd3,
        ST_CH3  = 3'd4,
        ST_DONE = 3'd5
    } pp_state_t;
endpackage

// File: rtl/phase_pacer_next.sv
module phase_pacer_next
    import phase_pacer_pkg::*;
(
    input  pp_state_t cur_i,
    input  logic      start_i,
    input  logic      slot_end_i,
    output pp_state_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (start_i) begin
            // START: any state -> READ, wins over a coincident strobe
            nxt_o = ST_READ;
        end else begin
            unique case (cur_i)
                ST_IDLE: nxt_o = ST_IDLE;
                ST_READ: nxt_o = slot_end_i ? ST_CH1  : ST_READ;  // TICK_READ / HOLD
                ST_CH1:  nxt_o = slot_end_i ? ST_CH2  : ST_CH1;   // TICK_CH1 / HOLD
                ST_CH2:  nxt_o = slot_end_i ? ST_CH3  : ST_CH2;   // TICK_CH2 / HOLD
                ST_CH3:  nxt_o = slot_end_i ? ST_DONE : ST_CH3;   // FINISH / HOLD
                ST_DONE: nxt_o = ST_DONE;
                default: nxt_o = ST_IDLE;                         // illegal code recovery
            endcase
        end
    end
endmodule

// File: rtl/phase_pacer_sreg.sv
module phase_pacer_sreg
    import phase_pacer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  pp_state_t nxt_i,
    output pp_state_t cur_o,
    output logic      restart_o
);
    logic enter_done;

    assign enter_done = (nxt_i == ST_DONE) && (cur_o != ST_DONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o     <= ST_IDLE;
            restart_o <= 1'b0;
        end else begin
            cur_o     <= nxt_i;
            restart_o <= start_i | enter_done;
        end
    end
endmodule

// File: rtl/phase_pacer_outs.sv
module phase_pacer_outs
    import phase_pacer_pkg::*;
#(
    parameter int C1_W = 2,
    parameter int C2_W = 4,
    parameter int C3_W = 4
) (
    input  pp_state_t         cur_i,
    input  logic [C1_W-1:0]   c1_act_i,
    input  logic [C2_W-1:0]   c2_act_i,
    input  logic [C3_W-1:0]   c3_act_i,
    output logic [PHASES-1:0] phase_o,
    output logic              done_o,
    output logic              conflict_o
);
    logic c1_busy, c2_busy, c3_busy;

    assign c1_busy = |c1_act_i;
    assign c2_busy = |c2_act_i;
    assign c3_busy = |c3_act_i;

    always_comb begin
        phase_o    = '0;
        done_o     = 1'b0;
        conflict_o = 1'b0;
        unique case (cur_i)
            ST_IDLE: ;
            ST_READ: phase_o[0] = 1'b1;
            ST_CH1: begin
                phase_o[1] = 1'b1;
                conflict_o = c1_busy & (c2_busy | c3_busy);
            end
            ST_CH2: begin
                phase_o[2] = 1'b1;
                conflict_o = c2_busy & ~c1_busy & c3_busy;
            end
            ST_CH3:  phase_o[3] = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/phase_pacer.sv
module phase_pacer
    import phase_pacer_pkg::*;
#(
    parameter int C1_W = 2,
    parameter int C2_W = 4,
    parameter int C3_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              slot_end_i,
    input  logic [C1_W-1:0]   c1_act_i,
    input  logic [C2_W-1:0]   c2_act_i,
    input  logic [C3_W-1:0]   c3_act_i,
    output logic [PHASES-1:0] phase_o,
    output logic              done_o,
    output logic              tmr_restart_o,
    output logic              conflict_o
);
    pp_state_t cur_st;
    pp_state_t nxt_st;

    phase_pacer_next u_next (
        .cur_i      (cur_st),
        .start_i    (start_i),
        .slot_end_i (slot_end_i),
        .nxt_o      (nxt_st)
    );

    phase_pacer_sreg u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .nxt_i     (nxt_st),
        .cur_o     (cur_st),
        .restart_o (tmr_restart_o)
    );

    phase_pacer_outs #(
        .C1_W (C1_W),
        .C2_W (C2_W),
        .C3_W (C3_W)
    ) u_outs (
        .cur_i      (cur_st),
        .c1_act_i   (c1_act_i),
        .c2_act_i   (c2_act_i),
        .c3_act_i   (c3_act_i),
        .phase_o    (phase_o),
        .done_o     (done_o),
        .conflict_o (conflict_o)
    );
endmodule

// File: rtl/phase_pacer_chk.sv
module phase_pacer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       slot_end_i,
    input logic [3:0] phase_o,
    input logic       done_o,
    input logic       tmr_restart_o,
    input logic       conflict_o
);
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phase_o, done_o}));                                      // R3

    AST_START_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (phase_o == 4'b0001 && !done_o));                      // R2

    AST_READ_TO_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && slot_end_i && phase_o == 4'b0001) |=> phase_o == 4'b0010); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !slot_end_i) |=> ($stable(phase_o) && $stable(done_o))); // R4

    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && slot_end_i && phase_o == 4'b1000) |=> (done_o && tmr_restart_o)); // R5

    AST_RESTART_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> tmr_restart_o);                                        // R6

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !slot_end_i) |=> !tmr_restart_o);                     // R6

    AST_CONFLICT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (phase_o[1] || phase_o[2]));                        // R9
endmodule

bind phase_pacer phase_pacer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .slot_end_i    (slot_end_i),
    .phase_o       (phase_o),
    .done_o        (done_o),
    .tmr_restart_o (tmr_restart_o),
    .conflict_o    (conflict_o)
);

// File: tb/tb_phase_pacer.sv
`timescale 1ns/1ps
module tb_phase_pacer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       slot_end_i = 1'b0;
    logic [1:0] c1_act_i = '0;
    logic [3:0] c2_act_i = '0;
    logic [3:0] c3_act_i = '0;
    logic [3:0] phase_o;
    logic       done_o;
    logic       tmr_restart_o;
    logic       conflict_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    phase_pacer dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .slot_end_i    (slot_end_i),
        .c1_act_i      (c1_act_i),
        .c2_act_i      (c2_act_i),
        .c3_act_i      (c3_act_i),
        .phase_o       (phase_o),
        .done_o        (done_o),
        .tmr_restart_o (tmr_restart_o),
        .conflict_o    (conflict_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge with the given controls, then sample 1 ns later
    task automatic step(input logic s, input logic t);
        start_i    = s;
        slot_end_i = t;
        @(posedge clk);
        #1;
        start_i    = 1'b0;
        slot_end_i = 1'b0;
    endtask

    task automatic set_act(input logic [1:0] a, input logic [3:0] b, input logic [3:0] c);
        c1_act_i = a;
        c2_act_i = b;
        c3_act_i = c;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 phase in reset", phase_o, 0);
        chk("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        chk("R1 phase after reset", phase_o, 0);
        chk("R1 restart after reset", tmr_restart_o, 0);
        chk("R1 conflict after reset", conflict_o, 0);
    endtask

    task automatic t_idle_ignore;
        step(1'b0, 1'b1);
        chk("R10 idle strobe phase", phase_o, 0);
        chk("R10 idle strobe done", done_o, 0);
        set_act(2'd3, 4'hF, 4'hF);
        chk("R9 idle conflict", conflict_o, 0);
        set_act(0, 0, 0);
    endtask

    task automatic t_full_run;
        step(1'b1, 1'b0);
        chk("R2 start to read", phase_o, 4'b0001);
        chk("R6 restart on start", tmr_restart_o, 1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        chk("R4 read held", phase_o, 4'b0001);
        chk("R6 restart single", tmr_restart_o, 0);
        set_act(2'd3, 4'hF, 4'hF);
        chk("R9 read conflict", conflict_o, 0);
        set_act(0, 0, 0);
        step(1'b0, 1'b1);
        chk("R3 read to ch1", phase_o, 4'b0010);
        step(1'b0, 1'b1);
        chk("R3 ch1 to ch2", phase_o, 4'b0100);
        step(1'b0, 1'b0);
        chk("R4 ch2 held", phase_o, 4'b0100);
        step(1'b0, 1'b1);
        chk("R3 ch2 to ch3", phase_o, 4'b1000);
        chk("R6 no restart mid run", tmr_restart_o, 0);
        set_act(2'd1, 4'h1, 4'h1);
        chk("R9 ch3 conflict", conflict_o, 0);
        set_act(0, 0, 0);
        step(1'b0, 1'b1);
        chk("R5 done flag", done_o, 1);
        chk("R5 done phase", phase_o, 0);
        chk("R6 restart on done", tmr_restart_o, 1);
        step(1'b0, 1'b0);
        chk("R6 done restart single", tmr_restart_o, 0);
        chk("R4 done held", done_o, 1);
        step(1'b0, 1'b1);
        chk("R5 done ignores strobe", done_o, 1);
        chk("R5 done phase stays", phase_o, 0);
        chk("R6 no restart in done", tmr_restart_o, 0);
        step(1'b1, 1'b0);
        chk("R2 start from done", phase_o, 4'b0001);
        chk("R5 done cleared", done_o, 0);
    endtask

    task automatic t_start_priority;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 reached ch2", phase_o, 4'b0100);
        step(1'b1, 1'b1);
        chk("R2 start beats strobe", phase_o, 4'b0001);
        chk("R6 restart with priority start", tmr_restart_o, 1);
    endtask

    task automatic t_conflict_ch1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R3 in ch1", phase_o, 4'b0010);
        set_act(2'd1, 4'h3, 4'h0);
        chk("R7 c1+c2", conflict_o, 1);
        set_act(2'd2, 4'h0, 4'h8);
        chk("R7 c1+c3", conflict_o, 1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R7 held during conflict", phase_o, 4'b0010);
        set_act(2'd3, 4'h0, 4'h0);
        chk("R7 c1 alone", conflict_o, 0);
        set_act(2'd0, 4'h5, 4'h5);
        chk("R7 c1 zero", conflict_o, 0);
        set_act(0, 0, 0);
    endtask

    task automatic t_conflict_ch2;
        step(1'b0, 1'b1);
        chk("R3 in ch2", phase_o, 4'b0100);
        set_act(2'd0, 4'h1, 4'h2);
        chk("R8 c2+c3", conflict_o, 1);
        set_act(2'd1, 4'h1, 4'h2);
        chk("R8 c1 nonzero", conflict_o, 0);
        set_act(2'd0, 4'h1, 4'h0);
        chk("R8 c3 zero", conflict_o, 0);
        set_act(2'd0, 4'h0, 4'h4);
        chk("R8 c2 zero", conflict_o, 0);
        set_act(0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_ignore();
        t_full_run();
        t_start_priority();
        t_conflict_ch1();
        t_conflict_ch2();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule